// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a small general-purpose I/O port, eight pins wide by default, that software reaches through a simple register interface. It keeps an output data register and an output-enable register. It also has a read-only view of the pins, taken after a two-flop synchroniser. Software can only set or clear output data bits and direction bits that appear in a fixed changeable-bit mask, so pins reserved for other uses cannot be disturbed.

Each pin has a 3-bit trigger mode. A pin can raise an interrupt on a high level, a low level, a rising edge, a falling edge or any edge. It can also assert its interrupt permanently, or stay silent. Triggers set sticky pending bits. Software clears a pending bit by writing a 1 to the acknowledge register. The pending bits are gated by an interrupt mask, and the gated bits are ORed into one interrupt line.

All accesses are single-cycle writes, with reads returned combinationally. The register offsets are: 0 output data, 1 set data bits, 2 clear data bits, 3 direction, 4 make-input, 5 make-output, 6 synchronised pins, 7 trigger modes, 8 interrupt mask, 9 acknowledge, 10 masked status, 11 raw pending. Reads of write-only or unused offsets return zero.

Top module: `gpio_port`

## Requirements
- R1: After reset, every readable register reads zero, pinOut and pinOe are zero, irq is low, and every pin's mode is 0 (off).
- R2: A write to offset 1 ORs (data & CHANGE_MASK) into the output data register, and a write to offset 2 clears those same bits. Bits outside CHANGE_MASK never change. Offset 0 and pinOut show the register.
- R3: A write to offset 5 sets the enable bits given by (data & CHANGE_MASK), and a write to offset 4 clears them. In this register 1 means output and 0 means input. Offset 3 and pinOe show the register.
- R4: Offset 6 returns pinIn passed through two flip-flops. A change on pinIn shows on the second rising edge after it, and not on the first.
- R5: In level modes the pending bit is set for as long as the level holds, and is set again right after an acknowledge while the level still holds. Mode 1 triggers on a high pin and mode 2 on a low pin.
- R6: In mode 3 (always) the pending bit is set every cycle, whatever the pin does.
- R7: Mode 4 sets pending on a rising edge, mode 5 on a falling edge and mode 6 on either edge. An edge is found by comparing the synchronised value with its value one cycle earlier. Once acknowledged, the bit stays clear until the next qualifying edge.
- R8: Modes 0 and 7 never set the pending bit.
- R9: Writing offset 9 clears each pending bit written as 1. Bits written as 0 are unaffected. A trigger in the same cycle as the acknowledge wins, so the bit stays set.
- R10: Offset 10 returns pending AND mask (mask at offset 8, readable), and irq is the OR of those bits.
- R11: Offset 7 holds the mode for pin i in bits [3i+2:3i] and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for reads and writes |
| regWrData | input | PINS*3 | Write data |
| regRdData | output | PINS*3 | Read data for regAddr, zero-extended |
| pinIn | input | PINS | Asynchronous pin levels |
| pinOut | output | PINS | Output data driven to the pads |
| pinOe | output | PINS | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is the interaction between an acknowledge and a trigger that is still active: a level or always-set pin must re-arm at once, while an edge pin must stay clear. The bench covers it by walking every pin through every mode value. Each walk has five phases: low, rise, acknowledge, fall and acknowledge. Each phase lasts long enough for the synchroniser and the pending flop to settle, and the whole pending register is compared after each phase. The same-cycle race is shown by reading pending on the cycle right after an acknowledge, with every pin in always mode.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_HIGH   = 3'd1,
    MODE_LOW    = 3'd2,
    MODE_ALWAYS = 3'd3,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_ANY    = 3'd6,
    MODE_SPARE  = 3'd7
  } gpio_mode_e;

  localparam logic [3:0] ADR_DATA  = 4'd0;
  localparam logic [3:0] ADR_SET   = 4'd1;
  localparam logic [3:0] ADR_CLR   = 4'd2;
  localparam logic [3:0] ADR_DIR   = 4'd3;
  localparam logic [3:0] ADR_MKIN  = 4'd4;
  localparam logic [3:0] ADR_MKOUT = 4'd5;
  localparam logic [3:0] ADR_PINS  = 4'd6;
  localparam logic [3:0] ADR_MODE  = 4'd7;
  localparam logic [3:0] ADR_MASK  = 4'd8;
  localparam logic [3:0] ADR_ACK   = 4'd9;
  localparam logic [3:0] ADR_MSTAT = 4'd10;
  localparam logic [3:0] ADR_PEND  = 4'd11;

  typedef struct packed {
    logic setData;
    logic clrData;
    logic mkIn;
    logic mkOut;
    logic modeWr;
    logic maskWr;
    logic ack;
  } strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic       regWrEn,
  input  logic [3:0] regAddr,
  output strobe_t    strb
);

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        ADR_SET:   strb.setData = 1'b1;
        ADR_CLR:   strb.clrData = 1'b1;
        ADR_MKIN:  strb.mkIn    = 1'b1;
        ADR_MKOUT: strb.mkOut   = 1'b1;
        ADR_MODE:  strb.modeWr  = 1'b1;
        ADR_MASK:  strb.maskWr  = 1'b1;
        ADR_ACK:   strb.ack     = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8,
  parameter logic [PINS-1:0] CHANGE_MASK = '1,
  localparam int MODE_W = 3,
  localparam int DW = PINS * MODE_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [DW-1:0]   wrData,
  input  logic [3:0]      rdAddr,
  output logic [DW-1:0]   rdData,
  input  logic [PINS-1:0] pinIn,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOe,
  output logic            irq
);

  logic [PINS-1:0] outData, oeReg, maskReg, pendReg;
  logic [PINS-1:0] sync1, pinSync, pinPrev, trig, ackBits, wBits;
  logic [DW-1:0]   modeReg;

  assign wBits   = wrData[PINS-1:0] & CHANGE_MASK;
  assign ackBits = strb.ack ? wrData[PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      oeReg   <= '0;
      maskReg <= '0;
      pendReg <= '0;
      modeReg <= '0;
      sync1   <= '0;
      pinSync <= '0;
      pinPrev <= '0;
    end else begin
      if (strb.setData)      outData <= outData | wBits;
      else if (strb.clrData) outData <= outData & ~wBits;
      if (strb.mkOut)        oeReg <= oeReg | wBits;
      else if (strb.mkIn)    oeReg <= oeReg & ~wBits;
      if (strb.modeWr)       modeReg <= wrData;
      if (strb.maskWr)       maskReg <= wrData[PINS-1:0];
      sync1   <= pinIn;
      pinSync <= sync1;
      pinPrev <= pinSync;
      pendReg <= (pendReg & ~ackBits) | trig;
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : gPin
    gpio_mode_e pinMode;
    assign pinMode = gpio_mode_e'(modeReg[g*MODE_W +: MODE_W]);
    always_comb begin
      unique case (pinMode)
        MODE_HIGH:   trig[g] = pinSync[g];
        MODE_LOW:    trig[g] = ~pinSync[g];
        MODE_ALWAYS: trig[g] = 1'b1;
        MODE_RISE:   trig[g] = pinSync[g] & ~pinPrev[g];
        MODE_FALL:   trig[g] = ~pinSync[g] & pinPrev[g];
        MODE_ANY:    trig[g] = pinSync[g] ^ pinPrev[g];
        default:     trig[g] = 1'b0;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADR_DATA:  rdData[PINS-1:0] = outData;
      ADR_DIR:   rdData[PINS-1:0] = oeReg;
      ADR_PINS:  rdData[PINS-1:0] = pinSync;
      ADR_MODE:  rdData = modeReg;
      ADR_MASK:  rdData[PINS-1:0] = maskReg;
      ADR_MSTAT: rdData[PINS-1:0] = pendReg & maskReg;
      ADR_PEND:  rdData[PINS-1:0] = pendReg;
      default:   rdData = '0;
    endcase
  end

  assign pinOut = outData;
  assign pinOe  = oeReg;
  assign irq    = |(pendReg & maskReg);

  AST_DATA_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setData || strb.clrData) |=> ((outData & ~CHANGE_MASK) == ($past(outData) & ~CHANGE_MASK))); // R2
  AST_DIR_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mkIn || strb.mkOut) |=> ((oeReg & ~CHANGE_MASK) == ($past(oeReg) & ~CHANGE_MASK))); // R3
  AST_TRIG_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (trig != '0) |=> ((pendReg & $past(trig)) == $past(trig))); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> ((pendReg & $past(ackBits & ~trig)) == '0)); // R9
  AST_ACK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> ((pendReg & ~$past(ackBits)) == ($past(pendReg) & ~$past(ackBits)) | ($past(trig) & ~$past(ackBits)))); // R9
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskWr && wrData[PINS-1:0] == '0) |=> !irq); // R10

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8,
  parameter logic [PINS-1:0] CHANGE_MASK = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [3:0]          regAddr,
  input  logic [PINS*3-1:0]   regWrData,
  output logic [PINS*3-1:0]   regRdData,
  input  logic [PINS-1:0]     pinIn,
  output logic [PINS-1:0]     pinOut,
  output logic [PINS-1:0]     pinOe,
  output logic                irq
);

  strobe_t strb;

  gpio_port_ctrl i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_port_dp #(
    .PINS        (PINS),
    .CHANGE_MASK (CHANGE_MASK)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (regWrData),
    .rdAddr (regAddr),
    .rdData (regRdData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irq    (irq)
  );

endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

  localparam int PINS = 8;
  localparam int DW = PINS * 3;
  localparam logic [PINS-1:0] CM = 8'h5F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut, pinOe;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port #(.PINS(PINS), .CHANGE_MASK(CM)) i_gpio_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    regWrEn = 1'b0; regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] modeWord(input int p, input int m);
    logic [DW-1:0] w = '0;
    w[p*3 +: 3] = 3'(m);
    return w;
  endfunction

  function automatic logic [DW-1:0] allModes(input int m);
    logic [DW-1:0] w = '0;
    for (int i = 0; i < PINS; i++) w[i*3 +: 3] = 3'(m);
    return w;
  endfunction

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [PINS-1:0] model;
    waitCyc(4);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check("R1 reset read", 32'(d), 32'h0);
    end
    check("R1 pinOut", 32'(pinOut), 0);
    check("R1 pinOe", 32'(pinOe), 0);
    check("R1 irq", 32'(irq), 0);

    // R2: set/clear filtered by changeable mask
    model = '0;
    for (int v = 0; v < 256; v++) begin
      wr(4'd1, DW'(v));
      model |= 8'(v) & CM;
      rd(4'd0, d);
      check("R2 set", 32'(d), 32'(model));
      wr(4'd2, DW'((v * 37) & 8'hFF));
      model &= ~(8'((v * 37) & 8'hFF) & CM);
      rd(4'd0, d);
      check("R2 clr", 32'(d), 32'(model));
      check("R2 pinOut", 32'(pinOut), 32'(model));
    end

    // R3: direction filtered by changeable mask
    model = '0;
    for (int v = 0; v < 256; v++) begin
      wr(4'd5, DW'(v));
      model |= 8'(v) & CM;
      rd(4'd3, d);
      check("R3 mkout", 32'(d), 32'(model));
      wr(4'd4, DW'((v * 91) & 8'hFF));
      model &= ~(8'((v * 91) & 8'hFF) & CM);
      rd(4'd3, d);
      check("R3 mkin", 32'(d), 32'(model));
      check("R3 pinOe", 32'(pinOe), 32'(model));
    end

    // R4: two-stage synchroniser latency
    for (int v = 1; v < 256; v++) begin
      pinIn = 8'(v);
      waitCyc(1);
      rd(4'd6, d);
      check("R4 not yet", 32'(d), 32'(v - 1));
      waitCyc(1);
      rd(4'd6, d);
      check("R4 synced", 32'(d), 32'(v));
    end
    pinIn = '0;
    waitCyc(3);

    // R5..R8, R11: every pin, every mode value
    wr(4'd8, DW'(8'hFF));
    for (int p = 0; p < PINS; p++) begin
      for (int m = 0; m < 8; m++) begin
        bit lvlH, lvlL, always_, rise, fall;
        bit eA, eB, eC, eD, eE;
        lvlH = (m == 1); lvlL = (m == 2); always_ = (m == 3);
        rise = (m == 4) || (m == 6); fall = (m == 5) || (m == 6);
        wr(4'd7, '0);
        pinIn = '0;
        waitCyc(3);
        wr(4'd9, DW'(8'hFF));
        wr(4'd7, modeWord(p, m));
        rd(4'd7, d);
        check("R11 mode readback", 32'(d), 32'(modeWord(p, m)));
        eA = lvlL || always_;
        eB = eA || lvlH || always_ || rise;
        eC = lvlH || always_;
        eD = eC || lvlL || always_ || fall;
        eE = lvlL || always_;
        waitCyc(3);
        rd(4'd11, d);
        check("R5 R6 R8 phase low", 32'(d), 32'(eA) << p);
        pinIn[p] = 1'b1;
        waitCyc(3);
        rd(4'd11, d);
        check("R7 R5 phase rise", 32'(d), 32'(eB) << p);
        check("R10 irq", 32'(irq), 32'(eB));
        wr(4'd9, DW'(8'hFF));
        waitCyc(3);
        rd(4'd11, d);
        check("R5 R7 after ack high", 32'(d), 32'(eC) << p);
        pinIn[p] = 1'b0;
        waitCyc(3);
        rd(4'd10, d);
        check("R7 R8 phase fall", 32'(d), 32'(eD) << p);
        wr(4'd9, DW'(8'hFF));
        waitCyc(3);
        rd(4'd11, d);
        check("R5 R6 after ack low", 32'(d), 32'(eE) << p);
      end
    end

    // R10: mask sweep with every pin always pending
    wr(4'd7, allModes(3));
    waitCyc(2);
    for (int v = 0; v < 256; v++) begin
      wr(4'd8, DW'(v));
      rd(4'd8, d);
      check("R10 mask readback", 32'(d), 32'(v));
      rd(4'd10, d);
      check("R10 masked status", 32'(d), 32'(v));
      check("R10 irq", 32'(irq), 32'(v != 0));
    end
    // R9: trigger beats acknowledge in the same cycle
    wr(4'd9, DW'(8'hFF));
    rd(4'd11, d);
    check("R9 trigger wins", 32'(d), 32'hFF);

    // R9: partial acknowledges with rising-edge pending on all pins
    wr(4'd7, allModes(4));
    wr(4'd9, DW'(8'hFF));
    waitCyc(2);
    pinIn = 8'hFF;
    waitCyc(3);
    model = 8'hFF;
    rd(4'd11, d);
    check("R7 all rise", 32'(d), 32'(model));
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a = (k == 0) ? 8'h00 : 8'(1 << (k - 1)) | 8'(8'h80 >> k);
      wr(4'd9, DW'(a));
      model &= ~a;
      rd(4'd11, d);
      check("R9 ack bits", 32'(d), 32'(model));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule